// File: doc/BRIEF.md
# Microcontroller Sleep Mode Controller

This block manages the low-power states of a small 8-bit processor core. Software programs a byte-wide control register that holds a sleep-enable flag and a 3-bit mode code. When the core executes its sleep instruction, it raises a one-cycle strobe. If the enable flag is set at that moment, the controller latches the mode and drops the clock-domain enables that the mode calls for. The domains are the CPU clock, the I/O clock, the converter clock, the asynchronous-timer clock and the main oscillator. While the block is asleep, the core is held halted.

An enabled interrupt pending from the interrupt controller starts the wake sequence. The oscillator is turned on first, and the controller waits out a per-mode start-up count. It then re-enables every clock and keeps the core halted for four more cycles. Finally it pulses an interrupt-dispatch signal for one cycle and returns to normal running. A synchronous reset request overrides this path in any state. It clears the control register and returns to running at once, and it tells the core to fetch from its reset vector. The controller drives no clear to the register file or memories, so their contents survive sleep.

States: ST_RUN (normal operation), ST_SLEEP (mode pattern applied), ST_STARTUP (oscillator settling), ST_HALT4 (four-cycle halt), ST_WAKE_IRQ (dispatch pulse). Transitions: RUN→SLEEP on strobe with enable set; SLEEP→STARTUP on interrupt when the mode's count is non-zero; SLEEP→HALT4 on interrupt when the count is zero; STARTUP→HALT4 when the count expires; HALT4→WAKE_IRQ after four cycles; WAKE_IRQ→RUN always; any state→RUN on reset request.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: A sleep strobe while running enters sleep only if reg bit 0 (enable) is 1; with bit 0 at 0, all clock enables stay 1 and core_halt stays 0.
- R2: While asleep, the enables {cpu,io,adc,async,osc} follow the latched mode in reg bits 3..1: 000 Idle = 01111, 001 ADC noise reduction = 00111, 010 Power-down = 00000, 011 Power-save = 00010, 110 Standby = 00001.
- R3: Register bits 7..4 always read 0, and writes to them are ignored; bits 3..0 read back the last value written.
- R4: After rst_n or a rst_wake cycle, the register reads 0, every clock enable is 1, and core_halt, irq_go are 0.
- R5: The reserved mode codes 100, 101 and 111 behave exactly as Idle, with the same enable pattern and a start-up count of 0.
- R6: On an interrupt while asleep, the controller spends the mode's start-up count in cycles with osc_en at 1 and the other enables at the sleep pattern; the count is 0 for Idle and ADC noise reduction.
- R7: After start-up, all clocks are enabled and core_halt stays 1 for exactly 4 cycles; then irq_go is 1 for one cycle with core_halt at 0, and the block runs.
- R8: rst_wake sampled in any state makes boot_vec 1 on the next cycle, with the block running and irq_go at 0, even if irq_pend is also high.
- R9: The register value is unchanged across a full sleep and wake sequence.
- R10: irq_pend while running has no effect on any output.
- R11: When a register write coincides with a sleep strobe, the sleep decision and the latched mode use the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_wake | input | 1 | Synchronous reset request from the chip's reset sources |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | One-cycle strobe from the executed sleep instruction |
| irq_pend | input | 1 | An enabled interrupt is pending |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | Converter clock enable |
| clk_async_en | output | 1 | Asynchronous-timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| core_halt | output | 1 | Holds the core halted |
| irq_go | output | 1 | One-cycle interrupt dispatch to the core |
| boot_vec | output | 1 | Core restarts from its reset vector |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a register write and a sleep strobe. The bench drives both on one edge, once setting and once clearing the enable bit, and checks that entry follows the old register value. The second pair is a reset request and a pending interrupt while the block is asleep, starting up or halting. Here the bench checks that boot_vec rises and that no dispatch pulse appears in any following cycle. A behavioural reference model runs beside the design and is compared on every cycle.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ADCNR = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_PSAVE = 3'b011;
    localparam logic [2:0] MODE_STBY  = 3'b110;

    localparam int HALT_CYCLES = 4;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STARTUP,
        ST_HALT4,
        ST_WAKE_IRQ
    } pwr_state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic asy;
        logic osc;
    } dom_en_t;

    localparam dom_en_t DOM_ALL_ON = 5'b11111;

endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg #(
    parameter int REG_W  = 8,
    parameter int LIVE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              se,
    output logic [LIVE_W-2:0] code
);

    logic [LIVE_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (we) begin
            q <= wdata[LIVE_W-1:0];
        end
    end

    // Unused upper bits are tied low on read.
    assign rdata = {{(REG_W-LIVE_W){1'b0}}, q};
    assign se    = q[0];
    assign code  = q[LIVE_W-1:1];

endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_sleep_pkg::*;
#(
    parameter int SU_PDOWN = 16,
    parameter int SU_PSAVE = 16,
    parameter int SU_STBY  = 6,
    parameter int CW       = 5
) (
    input  logic [2:0]    code,
    output dom_en_t       dom,
    output logic [CW-1:0] su
);

    always_comb begin
        unique case (code)
            MODE_ADCNR: begin
                dom = 5'b00111;
                su  = '0;
            end
            MODE_PDOWN: begin
                dom = 5'b00000;
                su  = CW'(SU_PDOWN);
            end
            MODE_PSAVE: begin
                dom = 5'b00010;
                su  = CW'(SU_PSAVE);
            end
            MODE_STBY: begin
                dom = 5'b00001;
                su  = CW'(SU_STBY);
            end
            default: begin
                // Idle and every reserved code: only the CPU clock stops.
                dom = 5'b01111;
                su  = '0;
            end
        endcase
    end

endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_wake,
    input  logic          sleep_req,
    input  logic          se,
    input  logic [2:0]    code_in,
    input  logic          irq_pend,
    input  logic [CW-1:0] su,
    input  dom_en_t       sleep_dom,
    output logic [2:0]    act_code,
    output dom_en_t       dom_out,
    output logic          core_halt,
    output logic          irq_go,
    output logic          boot_vec
);

    localparam logic [CW-1:0] HALT_LOAD = CW'(HALT_CYCLES - 1);

    pwr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [2:0]    code_q, code_d;
    logic          boot_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            code_q  <= MODE_IDLE;
            boot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            code_q  <= code_d;
            boot_q  <= rst_wake;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        code_d  = code_q;
        if (rst_wake) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            code_d  = MODE_IDLE;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sleep_req && se) begin
                        state_d = ST_SLEEP;
                        code_d  = code_in;
                    end
                end
                ST_SLEEP: begin
                    if (irq_pend) begin
                        if (su == '0) begin
                            state_d = ST_HALT4;
                            cnt_d   = HALT_LOAD;
                        end else begin
                            state_d = ST_STARTUP;
                            cnt_d   = su - 1'b1;
                        end
                    end
                end
                ST_STARTUP: begin
                    if (cnt_q == '0) begin
                        state_d = ST_HALT4;
                        cnt_d   = HALT_LOAD;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_HALT4: begin
                    if (cnt_q == '0) begin
                        state_d = ST_WAKE_IRQ;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_WAKE_IRQ: begin
                    state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_RUN;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        dom_out   = DOM_ALL_ON;
        core_halt = 1'b0;
        irq_go    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                dom_out = DOM_ALL_ON;
            end
            ST_SLEEP: begin
                dom_out   = sleep_dom;
                core_halt = 1'b1;
            end
            ST_STARTUP: begin
                dom_out     = sleep_dom;
                dom_out.osc = 1'b1;
                core_halt   = 1'b1;
            end
            ST_HALT4: begin
                core_halt = 1'b1;
            end
            ST_WAKE_IRQ: begin
                irq_go = 1'b1;
            end
            default: begin
                dom_out = DOM_ALL_ON;
            end
        endcase
    end

    assign act_code = code_q;
    assign boot_vec = boot_q;

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int SU_PDOWN = 16,
    parameter int SU_PSAVE = 16,
    parameter int SU_STBY  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_wake,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sleep_req,
    input  logic             irq_pend,
    output logic             clk_cpu_en,
    output logic             clk_io_en,
    output logic             clk_adc_en,
    output logic             clk_async_en,
    output logic             osc_en,
    output logic             core_halt,
    output logic             irq_go,
    output logic             boot_vec
);

    localparam int LIVE_W = 4;
    localparam int SU_A   = (SU_PDOWN > SU_PSAVE) ? SU_PDOWN : SU_PSAVE;
    localparam int SU_MAX = (SU_A > SU_STBY) ? SU_A : SU_STBY;
    localparam int CW     = $clog2(SU_MAX + HALT_CYCLES + 1);

    logic          se;
    logic [2:0]    reg_code;
    logic [2:0]    act_code;
    logic [CW-1:0] su;
    dom_en_t       sleep_dom;
    dom_en_t       dom_out;

    pwr_ctl_reg #(
        .REG_W (REG_W),
        .LIVE_W(LIVE_W)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rst_wake),
        .we   (reg_we),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .se   (se),
        .code (reg_code)
    );

    pwr_mode_decode #(
        .SU_PDOWN(SU_PDOWN),
        .SU_PSAVE(SU_PSAVE),
        .SU_STBY (SU_STBY),
        .CW      (CW)
    ) u_dec (
        .code(act_code),
        .dom (sleep_dom),
        .su  (su)
    );

    pwr_wake_fsm #(
        .CW(CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_wake (rst_wake),
        .sleep_req(sleep_req),
        .se       (se),
        .code_in  (reg_code),
        .irq_pend (irq_pend),
        .su       (su),
        .sleep_dom(sleep_dom),
        .act_code (act_code),
        .dom_out  (dom_out),
        .core_halt(core_halt),
        .irq_go   (irq_go),
        .boot_vec (boot_vec)
    );

    assign clk_cpu_en   = dom_out.cpu;
    assign clk_io_en    = dom_out.io;
    assign clk_adc_en   = dom_out.adc;
    assign clk_async_en = dom_out.asy;
    assign osc_en       = dom_out.osc;

endmodule

module pwr_sleep_ctrl_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_wake,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_rdata,
    input logic             sleep_req,
    input logic             irq_pend,
    input logic             clk_cpu_en,
    input logic             clk_io_en,
    input logic             clk_adc_en,
    input logic             clk_async_en,
    input logic             osc_en,
    input logic             core_halt,
    input logic             irq_go,
    input logic             boot_vec
);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:4] == '0);

    a_r1_no_entry_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && !irq_go && sleep_req && !reg_rdata[0]) |=> !core_halt);

    a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wake |=> (boot_vec && !irq_go && !core_halt && clk_cpu_en));

    a_r7_dispatch_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_go |=> !irq_go);

    a_r7_dispatch_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_wake && core_halt && clk_cpu_en && $past(core_halt) && $past(clk_cpu_en)
         && $past(core_halt, 2) && $past(clk_cpu_en, 2) && $past(core_halt, 3)
         && $past(clk_cpu_en, 3)) |=> irq_go);

    a_r6_halted_when_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_cpu_en |-> core_halt);

    a_r2_osc_off_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!clk_cpu_en && !clk_io_en && !clk_adc_en));

    a_r10_no_dispatch_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && !irq_go) |=> !irq_go);

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SU_PD = 16;
    localparam int SU_PS = 16;
    localparam int SU_SB = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_wake = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       irq_pend = 1'b0;
    logic       clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en;
    logic       core_halt, irq_go, boot_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_sleep_ctrl #(
        .REG_W(8), .SU_PDOWN(SU_PD), .SU_PSAVE(SU_PS), .SU_STBY(SU_SB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_wake(rst_wake), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .irq_pend(irq_pend), .clk_cpu_en(clk_cpu_en), .clk_io_en(clk_io_en),
        .clk_adc_en(clk_adc_en), .clk_async_en(clk_async_en), .osc_en(osc_en),
        .core_halt(core_halt), .irq_go(irq_go), .boot_vec(boot_vec)
    );

    // Reference model: 0 run, 1 asleep, 2 starting, 3 halted, 4 dispatch
    int       m_st = 0;
    int       m_left = 0;
    bit [2:0] m_mode = 0;
    bit [3:0] m_reg = 0;
    bit       m_boot = 0;
    bit       model_on = 0;

    function automatic bit [4:0] mode_pattern(bit [2:0] c);
        if (c == 3'd1) return 5'b00111;
        if (c == 3'd2) return 5'b00000;
        if (c == 3'd3) return 5'b00010;
        if (c == 3'd6) return 5'b00001;
        return 5'b01111;
    endfunction

    function automatic int mode_startup(bit [2:0] c);
        if (c == 3'd2) return SU_PD;
        if (c == 3'd3) return SU_PS;
        if (c == 3'd6) return SU_SB;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_mode = 0; m_reg = 0; m_boot = 0;
        end else begin
            bit [3:0] old_reg;
            old_reg = m_reg;
            m_boot  = rst_wake;
            if (rst_wake) begin
                m_st = 0; m_reg = 0; m_mode = 0;
            end else begin
                if (reg_we) m_reg = reg_wdata[3:0];
                case (m_st)
                    0: if (sleep_req && old_reg[0]) begin
                        m_st = 1; m_mode = old_reg[3:1];
                    end
                    1: if (irq_pend) begin
                        if (mode_startup(m_mode) == 0) begin
                            m_st = 3; m_left = 4;
                        end else begin
                            m_st = 2; m_left = mode_startup(m_mode);
                        end
                    end
                    2: begin
                        m_left--;
                        if (m_left == 0) begin m_st = 3; m_left = 4; end
                    end
                    3: begin
                        m_left--;
                        if (m_left == 0) m_st = 4;
                    end
                    default: m_st = 0;
                endcase
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            bit [4:0] e_dom, a_dom;
            a_dom = {clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en};
            if (m_st == 1) e_dom = mode_pattern(m_mode);
            else if (m_st == 2) e_dom = mode_pattern(m_mode) | 5'b00001;
            else e_dom = 5'b11111;
            check(a_dom == e_dom, "R2 R5 R6 enables", a_dom, e_dom);
            check(core_halt == (m_st >= 1 && m_st <= 3), "R7 core_halt",
                  core_halt, (m_st >= 1 && m_st <= 3));
            check(irq_go == (m_st == 4), "R7 R10 irq_go", irq_go, (m_st == 4));
            check(boot_vec == m_boot, "R8 boot_vec", boot_vec, m_boot);
            check(reg_rdata == {4'h0, m_reg}, "R3 R9 reg_rdata", reg_rdata, {4'h0, m_reg});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit [7:0] v);
        @(negedge clk); reg_we = 1; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1;
        @(negedge clk); sleep_req = 0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_pend = 1;
        @(negedge clk); irq_pend = 0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst_wake = 1;
        @(negedge clk); rst_wake = 0;
    endtask

    // Full cycle through one mode, with directed timing checks
    task automatic run_mode(bit [2:0] c);
        int su;
        su = mode_startup(c);
        wr({4'b1010, c, 1'b1});
        pulse_sleep();
        check(core_halt == 1, "R1 entry with enable", core_halt, 1);
        check({clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en} == mode_pattern(c),
              (c inside {3'd4, 3'd5, 3'd7}) ? "R5 reserved as idle" : "R2 sleep pattern",
              {clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en}, mode_pattern(c));
        step(3);
        @(negedge clk); irq_pend = 1;
        @(negedge clk); irq_pend = 0;
        if (su > 0) begin
            check(osc_en == 1 && clk_cpu_en == 0, "R6 startup osc on", osc_en, 1);
            step(su - 1);
            @(negedge clk);
        end
        check(clk_cpu_en == 1 && core_halt == 1, "R7 halt begins", core_halt, 1);
        step(3);
        check(core_halt == 1 && irq_go == 0, "R7 fourth halt cycle", irq_go, 0);
        @(negedge clk);
        check(irq_go == 1 && core_halt == 0, "R7 dispatch", irq_go, 1);
        @(negedge clk);
        check(irq_go == 0 && core_halt == 0, "R7 running again", irq_go, 0);
        check(reg_rdata == {4'h0, c, 1'b1}, "R9 register preserved", reg_rdata, {4'h0, c, 1'b1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        @(negedge clk); rst_n = 1; model_on = 1;
        @(negedge clk);
        check(reg_rdata == 0 && core_halt == 0 && clk_cpu_en && osc_en,
              "R4 reset state", reg_rdata, 0);

        // R3: upper bits dropped
        wr(8'hF4);
        check(reg_rdata == 8'h04, "R3 upper bits ignored", reg_rdata, 8'h04);

        // R1: strobe with enable at zero
        pulse_sleep();
        check(core_halt == 0 && clk_cpu_en == 1, "R1 no entry without enable", core_halt, 0);

        // R10: interrupt while running
        pulse_irq();
        check(irq_go == 0, "R10 irq ignored while running", irq_go, 0);

        // Every mode code, including reserved ones
        for (int c = 0; c < 8; c++) run_mode(c[2:0]);

        // R11: write and strobe in the same cycle
        wr(8'h04);
        @(negedge clk); reg_we = 1; reg_wdata = 8'h05; sleep_req = 1;
        @(negedge clk); reg_we = 0; sleep_req = 0;
        check(core_halt == 0, "R11 old enable 0 blocks entry", core_halt, 0);
        @(negedge clk); reg_we = 1; reg_wdata = 8'h00; sleep_req = 1;
        @(negedge clk); reg_we = 0; sleep_req = 0;
        check(core_halt == 1 && clk_io_en == 0 && osc_en == 0,
              "R11 old enable 1 enters power-down", core_halt, 1);
        pulse_irq();
        step(SU_PD + 8);

        // R8: reset coinciding with interrupt while asleep
        wr(8'h05);
        pulse_sleep();
        @(negedge clk); rst_wake = 1; irq_pend = 1;
        @(negedge clk); rst_wake = 0; irq_pend = 0;
        check(boot_vec == 1 && irq_go == 0 && core_halt == 0, "R8 reset beats irq", boot_vec, 1);
        check(reg_rdata == 0, "R4 register cleared by reset request", reg_rdata, 0);
        step(8);

        // R8: reset during startup and during halt
        wr(8'h07);
        pulse_sleep();
        pulse_irq();
        step(4);
        pulse_rst();
        check(boot_vec == 1 && core_halt == 0, "R8 reset during startup", boot_vec, 1);
        step(10);
        wr(8'h01);
        pulse_sleep();
        pulse_irq();
        step(1);
        pulse_rst();
        check(boot_vec == 1 && irq_go == 0, "R8 reset during halt", irq_go, 0);
        step(10);

        // R4: asynchronous reset while asleep
        wr(8'h0D);
        pulse_sleep();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(reg_rdata == 0 && core_halt == 0 && clk_cpu_en == 1, "R4 async reset", reg_rdata, 0);
        step(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule